// File: doc/BRIEF.md
# Serial 1011 Pattern Detector in Reversible Cells

This block watches a one-bit serial stream, one bit per rising clock edge, and raises `detect_o` in the cycle that the last bit of the pattern 1011 is presented. The output is Mealy style. It is driven combinationally from the current input while the machine holds the "101 seen" state, so it rises in the same cycle as the final 1 and never later.

A build-time parameter `OVERLAP` sets how the machine recovers after a hit. In overlapping mode the final 1 of a match also serves as the first 1 of the next match. In non-overlapping mode every bit of a match is used up, and the search starts again from idle.

All next-state and output logic is a structural netlist of two reversible cells and nothing else. A controlled-NOT cell works as a copier or an inverter. A controlled-swap cell works as an AND or an OR, with one input tied to a constant. Outputs that the netlist does not need are left as garbage. The two state bits sit in ordinary flip-flops.

Top module: `rev_seq_detector`

## Requirements
- R1: While `rst_ni` is low, the state is idle (00) and `detect_o` is 0, whatever `din_i` is.
- R2: The state code is two bits {A,B}: idle = 00, "1" seen = 01, "10" seen = 10, "101" seen = 11. A 0 received in idle leaves the machine in idle. A 0 received after "10" returns it to idle.
- R3: `detect_o` is 1 only when the state is 11 and `din_i` is 1, in the same cycle as that input bit.
- R4: `detect_o` is never high in two consecutive cycles.
- R5: With `OVERLAP`=1, a hit moves the machine to state 01. The input 010110110110 gives 000010010010, and the input 10110111 gives 00010010.
- R6: With `OVERLAP`=0, a hit moves the machine to idle. The input 010110110110 gives 000010000010, and the input 10110111 gives 00010000.
- R7: Asserting `rst_ni` low in the middle of a pattern discards the partial match. A complete 1011 must follow before the next detection.
- R8: The combinational logic uses only controlled-NOT and controlled-swap cells: at most 14 cells when `OVERLAP`=1 and at most 18 when `OVERLAP`=0. Every controlled-swap cell has the same number of ones on its outputs as on its inputs. Over any stream, the outputs equal those of a behavioural pattern matcher built for the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Serial data bit |
| detect_o | output | 1 | Mealy detect pulse for 1011 |

## Verification
The bench builds two copies side by side, one with `OVERLAP`=1 and one with `OVERLAP`=0, and feeds both the same stream. Each cycle, each copy is compared with its own expected value. Because both modes see identical input, the cases where the two outputs differ can be observed directly: a match whose leading 1 is the trailing 1 of the previous match, and runs like 1011011. Random streams with varying densities of ones, plus resets in the middle of a pattern, drive each copy through every state-and-input pair, including all the recovery arcs.

// File: rtl/rev_seq_pkg.sv
package rev_seq_pkg;
  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 2'b00,
    ST_1    = 2'b01,
    ST_10   = 2'b10,
    ST_101  = 2'b11
  } det_state_e;

  localparam int CNOT_CELLS    = 3;
  localparam int CSWAP_OVL     = 6;
  localparam int CSWAP_NOV     = 9;
  localparam int BUDGET_OVL    = 14;
  localparam int BUDGET_NOV    = 18;
endpackage

// File: rtl/rev_cnot.sv
// Controlled-NOT: control passes through, target is xored with control.
module rev_cnot (
  input  logic ctl_i,
  input  logic tgt_i,
  output logic ctl_o,
  output logic tgt_o
);
  assign ctl_o = ctl_i;
  assign tgt_o = ctl_i ^ tgt_i;
endmodule

// File: rtl/rev_cswap.sv
// Controlled-swap: when sel_i is high, the two data lines trade places.
module rev_cswap (
  input  logic sel_i,
  input  logic p_i,
  input  logic q_i,
  output logic sel_o,
  output logic p_o,
  output logic q_o
);
  assign sel_o = sel_i;
  assign p_o   = (~sel_i & p_i) ^ (sel_i & q_i);
  assign q_o   = (~sel_i & q_i) ^ (sel_i & p_i);
endmodule

// File: rtl/rev_seq_logic.sv
// Next-state and Mealy output built only from reversible cells.
// AND(u,v): cswap(sel=u, p=v, q=0) -> q_o.  OR(u,v): cswap(sel=u, p=1, q=v) -> q_o.
module rev_seq_logic
  import rev_seq_pkg::*;
#(
  parameter bit OVERLAP = 1'b1
) (
  input  logic a_i,
  input  logic b_i,
  input  logic x_i,
  output logic da_o,
  output logic db_o,
  output logic y_o
);
  localparam int NC = CNOT_CELLS;
  localparam int NF = OVERLAP ? CSWAP_OVL : CSWAP_NOV;

  logic c_a [NC];
  logic c_b [NC];
  logic c_x [NC];
  logic c_y [NC];
  logic f_s [NF];
  logic f_p [NF];
  logic f_q [NF];
  logic f_so [NF];
  logic f_po [NF];
  logic f_qo [NF];

  for (genvar gi = 0; gi < NC; gi++) begin : g_cnot
    rev_cnot u_cnot (
      .ctl_i(c_a[gi]), .tgt_i(c_b[gi]), .ctl_o(c_x[gi]), .tgt_o(c_y[gi])
    );
  end

  for (genvar gj = 0; gj < NF; gj++) begin : g_cswap
    rev_cswap u_cswap (
      .sel_i(f_s[gj]), .p_i(f_p[gj]), .q_i(f_q[gj]),
      .sel_o(f_so[gj]), .p_o(f_po[gj]), .q_o(f_qo[gj])
    );
  end

  logic b_n, x_n;

  // inverters
  assign c_a[0] = b_i;      assign c_b[0] = 1'b1;  assign b_n = c_y[0];
  assign c_a[1] = x_i;      assign c_b[1] = 1'b1;  assign x_n = c_y[1];

  // DA = A.B'.X + B.X'
  assign f_s[0] = a_i;      assign f_p[0] = b_n;   assign f_q[0] = 1'b0;
  assign f_s[1] = f_qo[0];  assign f_p[1] = x_i;   assign f_q[1] = 1'b0;
  assign f_s[2] = b_i;      assign f_p[2] = x_n;   assign f_q[2] = 1'b0;
  assign f_s[3] = f_qo[1];  assign f_p[3] = 1'b1;  assign f_q[3] = f_qo[2];
  assign da_o   = f_qo[3];

  // Y = A.B.X
  assign f_s[4] = a_i;      assign f_p[4] = b_i;   assign f_q[4] = 1'b0;
  assign f_s[5] = f_qo[4];  assign f_p[5] = x_i;   assign f_q[5] = 1'b0;
  assign y_o    = f_qo[5];

  if (OVERLAP) begin : g_db_ovl
    // DB = X, taken through a copier
    assign c_a[2] = x_i;    assign c_b[2] = 1'b0;
    assign db_o   = c_y[2];
  end else begin : g_db_nov
    // DB = A'.X + B'.X
    assign c_a[2] = a_i;    assign c_b[2] = 1'b1;
    assign f_s[6] = c_y[2]; assign f_p[6] = x_i;   assign f_q[6] = 1'b0;
    assign f_s[7] = b_n;    assign f_p[7] = x_i;   assign f_q[7] = 1'b0;
    assign f_s[8] = f_qo[6]; assign f_p[8] = 1'b1; assign f_q[8] = f_qo[7];
    assign db_o   = f_qo[8];
  end

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      AST_CSWAP_CONSERVE: assert ($countones({f_so[i], f_po[i], f_qo[i]}) ==
                                  $countones({f_s[i], f_p[i], f_q[i]})); // R8
    end
    for (int k = 0; k < NC; k++) begin
      AST_CNOT_RECOVER: assert (c_x[k] == c_a[k] && (c_x[k] ^ c_y[k]) == c_b[k]); // R8
    end
  end

  initial begin
    AST_CELL_BUDGET: assert (NC + NF <= (OVERLAP ? BUDGET_OVL : BUDGET_NOV)); // R8
  end
endmodule

// File: rtl/rev_seq_detector.sv
module rev_seq_detector
  import rev_seq_pkg::*;
#(
  parameter bit OVERLAP = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic detect_o
);
  logic [ST_W-1:0] state_q;
  logic            da, db;

  rev_seq_logic #(.OVERLAP(OVERLAP)) u_logic (
    .a_i (state_q[1]),
    .b_i (state_q[0]),
    .x_i (din_i),
    .da_o(da),
    .db_o(db),
    .y_o (detect_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= {da, db};
  end

  AST_HIT_ONLY_IN_101: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> (state_q == ST_101 && din_i)); // R3
  AST_HIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |=> !detect_o); // R4
  AST_IDLE_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !din_i) |=> state_q == ST_IDLE); // R2
  AST_IDLE_TO_1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && din_i) |=> state_q == ST_1); // R2
  AST_10_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_10 && !din_i) |=> state_q == ST_IDLE); // R2

  if (OVERLAP) begin : g_ast_ovl
    AST_OVL_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      detect_o |=> state_q == ST_1); // R5
  end else begin : g_ast_nov
    AST_NOV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      detect_o |=> state_q == ST_IDLE); // R6
  end
endmodule

// File: tb/rev_seq_detector_bench.sv
module rev_seq_detector_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic det_ovl, det_nov;

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_seq_detector #(.OVERLAP(1'b1)) u_rev_seq_detector (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .detect_o(det_ovl)
  );
  rev_seq_detector #(.OVERLAP(1'b0)) u_rev_seq_detector_nov (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .detect_o(det_nov)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] hist = 4'b0;
  int n_valid = 0;
  int nov_cnt = 0;
  logic eo, en;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: a hit ends a 1011 window; non-overlap needs the window to start after the last hit.
  task automatic step(input logic b, input string req, output logic xo, output logic xn);
    @(negedge clk);
    din = b;
    #1;
    hist = {hist[2:0], b};
    if (n_valid < 15) n_valid++;
    if (nov_cnt < 15) nov_cnt++;
    xo = (n_valid >= 4) && (hist == 4'b1011);
    xn = xo && (nov_cnt >= 4);
    if (xn) nov_cnt = 0;
    chk({req, " ovl"}, det_ovl, xo);
    chk({req, " nov"}, det_nov, xn);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b1;
    #1;
    chk("R1 detect low in reset ovl", det_ovl, 1'b0);
    chk("R1 detect low in reset nov", det_nov, 1'b0);
    hist = 4'b0; n_valid = 0; nov_cnt = 0;
    @(negedge clk);
    din = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic [15:0] v, input int n, input logic [15:0] vo,
                         input logic [15:0] vn, input string req);
    do_reset();
    for (int i = n - 1; i >= 0; i--) begin
      step(v[i], req, eo, en);
      chk({req, " example ovl"}, det_ovl, vo[i]);
      chk({req, " example nov"}, det_nov, vn[i]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset holds idle even with ones on the input
    repeat (2) @(negedge clk);
    din = 1'b1;
    #1;
    chk("R1 reset ovl", det_ovl, 1'b0);
    chk("R1 reset nov", det_nov, 1'b0);
    do_reset();

    // R2: zeros in idle, 100 falls back, then a clean 1011
    for (int i = 0; i < 5; i++) step(1'b0, "R2 idle zeros", eo, en);
    step(1'b1, "R2", eo, en); step(1'b0, "R2", eo, en); step(1'b0, "R2 10-0 to idle", eo, en);
    step(1'b1, "R2", eo, en);
    chk("R2 no hit on 1001", det_ovl, 1'b0);
    step(1'b0, "R2", eo, en); step(1'b1, "R2", eo, en); step(1'b1, "R3 hit", eo, en);
    chk("R3 hit same cycle ovl", det_ovl, 1'b1);
    chk("R3 hit same cycle nov", det_nov, 1'b1);
    step(1'b1, "R4", eo, en);
    chk("R4 no second cycle ovl", det_ovl, 1'b0);
    chk("R4 no second cycle nov", det_nov, 1'b0);

    // R5 / R6 examples
    run_vec(16'b010110110110, 12, 16'b000010010010, 16'b000010000010, "R5 R6 stream A");
    run_vec(16'b10110111, 8, 16'b00010010, 16'b00010000, "R5 R6 stream B");

    // R7: reset after 101 discards the partial match
    do_reset();
    step(1'b1, "R7", eo, en); step(1'b0, "R7", eo, en); step(1'b1, "R7", eo, en);
    do_reset();
    step(1'b1, "R7 after reset", eo, en);
    chk("R7 partial discarded ovl", det_ovl, 1'b0);
    chk("R7 partial discarded nov", det_nov, 1'b0);
    step(1'b0, "R7", eo, en); step(1'b1, "R7", eo, en); step(1'b1, "R7 fresh hit", eo, en);
    chk("R7 fresh hit ovl", det_ovl, 1'b1);

    // R8: random streams with varying density and occasional resets
    for (int blk = 0; blk < 8; blk++) begin
      int dens;
      dens = 30 + 10 * (blk % 5);
      for (int i = 0; i < 400; i++) begin
        if (($urandom % 150) == 0) do_reset();
        step((($urandom % 100) < dens) ? 1'b1 : 1'b0, "R8 random", eo, en);
      end
    end

    finish_run();
  end
endmodule